// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects up to 32 interrupt source lines into one level-sensitive request line for a processor. Each source owns one status bit and one enable bit. A source line going high sets its status bit, and a source line going low clears it. Software reaches the state through a small synchronous register bus with a byte address, read and write strobes, and 32-bit write and read data.

Software can read the raw status, clear status bits by writing ones, load the whole status word directly, program the enable mask, and read the status already masked by the enables. The processor request is a registered OR of status AND enable, so it follows any change one clock later. A source may be wired to a status bit in direct order or in reversed order, which is chosen by a parameter. Any access that the register map does not support is answered safely and flagged with a one-cycle error pulse.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is high and after it is released, status and enable are zero, and `irq_o`, `err_o` and `rdata_o` are all low.
- R2: A rising edge on source line i sets status bit i, and a falling edge clears it. A line that holds its level changes nothing. The default mapping is line i to bit i.
- R3: A write to offset 0x00 clears every status bit whose write-data bit is one. A read of 0x00 returns the raw status.
- R4: A write to offset 0x04 loads the write data into the status word, replacing all bits. A read of 0x04 returns the status and pulses `err_o`.
- R5: A write to offset 0x08 replaces the enable mask. A read of 0x08 returns the mask.
- R6: A read of offset 0x0C returns status AND enable. A write to 0x0C changes no state and pulses `err_o`.
- R7: `irq_o` is high in the cycle after (status AND enable) is non-zero, and low in the cycle after it is zero.
- R8: Any other offset, including misaligned ones, reads as zero and ignores writes. Such an access pulses `err_o` high for exactly one cycle, in the cycle after the access.
- R9: When a source-line edge and a software write hit the same status bit in the same cycle, the line edge decides the bit.
- R10: Read data is registered. It appears in the cycle after `rd_en_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_SRC | Interrupt source lines |
| addr_i | input | ADDR_W | Register byte offset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse for an unexpected access |
| irq_o | output | 1 | Level interrupt request to the processor |

## Verification
The bench targets three kinds of mistake.

- Same-cycle conflicts between a line edge and a clear or load. A design that lets the write win would leave a freshly raised source lost, or a dropped source stuck high.
- Clearing while a line stays high. A design that treats the line as a level rather than an edge would re-set the bit at once, and software could never acknowledge it.
- Timing and decoding. The bench checks the one-cycle latency of `irq_o` and of read data, and a late or combinational output would show up as an off-by-one cycle. It also checks the status-set, masked-status and unmapped offsets, where a loose decoder would alias a register or corrupt state on an ignored write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned OFS_STAT = 'h00;
   localparam int unsigned OFS_SET  = 'h04;
   localparam int unsigned OFS_ENA  = 'h08;
   localparam int unsigned OFS_MASK = 'h0C;

   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_SET  = 2'd1,
      SEL_ENA  = 2'd2,
      SEL_MASK = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
   import irqc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   output logic              hit_o,
   output reg_sel_e          sel_o,
   output logic              wr_stat_o,
   output logic              wr_set_o,
   output logic              wr_ena_o,
   output logic              bad_o
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("irqc_decode: ADDR_W must be at least 4");
      end
   endgenerate

   always_comb begin
      hit_o = 1'b1;
      sel_o = SEL_STAT;
      unique case (addr_i)
         ADDR_W'(OFS_STAT): sel_o = SEL_STAT;
         ADDR_W'(OFS_SET):  sel_o = SEL_SET;
         ADDR_W'(OFS_ENA):  sel_o = SEL_ENA;
         ADDR_W'(OFS_MASK): sel_o = SEL_MASK;
         default:           hit_o = 1'b0;
      endcase
   end

   assign wr_stat_o = wr_en_i && hit_o && (sel_o == SEL_STAT);
   assign wr_set_o  = wr_en_i && hit_o && (sel_o == SEL_SET);
   assign wr_ena_o  = wr_en_i && hit_o && (sel_o == SEL_ENA);
   assign bad_o     = (rd_en_i && (!hit_o || sel_o == SEL_SET)) ||
                      (wr_en_i && (!hit_o || sel_o == SEL_MASK));
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
   parameter int unsigned NUM_SRC      = 32,
   parameter bit          SRC_REVERSED = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_stat_i,
   input  logic               wr_set_i,
   input  logic               wr_ena_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] status_o,
   output logic [NUM_SRC-1:0] enable_o
);
   logic [NUM_SRC-1:0] line_v, line_q, rise, fall, base, status_q, enable_q;
   logic armed_q;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_map
         if (SRC_REVERSED) begin : g_rev
            assign line_v[NUM_SRC-1-k] = src_i[k];
         end else begin : g_dir
            assign line_v[k] = src_i[k];
         end
      end
   endgenerate

   assign rise = line_v & ~line_q;
   assign fall = ~line_v & line_q;

   always_comb begin
      base = status_q;
      if (wr_stat_i)     base = status_q & ~wdata_i;
      else if (wr_set_i) base = wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         line_q   <= '0;
         status_q <= '0;
         enable_q <= '0;
         armed_q  <= 1'b0;
      end else begin
         line_q   <= line_v;
         status_q <= (base & ~fall) | rise;
         if (wr_ena_i) enable_q <= wdata_i;
         armed_q  <= 1'b1;
      end
   end

   assign status_o = status_q;
   assign enable_o = enable_q;

   // R2 R9
   rise_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      armed_q |-> ((status_q & $past(rise)) == $past(rise)));
   // R2 R9
   fall_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      armed_q |-> ((status_q & $past(fall)) == '0));
   // R5
   enable_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_q && $past(wr_ena_i)) |-> (enable_q == $past(wdata_i)));
   // R5 R6 R8
   enable_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_q && !$past(wr_ena_i)) |-> $stable(enable_q));
endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] enable_i,
   output logic               irq_o
);
   logic irq_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) irq_q <= 1'b0;
      else       irq_q <= |(status_i & enable_i);
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC      = 32,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          SRC_REVERSED = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               rd_en_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               err_o,
   output logic               irq_o
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_num_src
         $error("irq_status_ctrl: NUM_SRC must be 1..DATA_W");
      end
   endgenerate

   logic               hit, wr_stat, wr_set, wr_ena, bad;
   reg_sel_e           sel;
   logic [NUM_SRC-1:0] status, enable, rd_bits;
   logic [DATA_W-1:0]  rdata_q;
   logic               err_q, armed_q;

   irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i   (addr_i),
      .rd_en_i  (rd_en_i),
      .wr_en_i  (wr_en_i),
      .hit_o    (hit),
      .sel_o    (sel),
      .wr_stat_o(wr_stat),
      .wr_set_o (wr_set),
      .wr_ena_o (wr_ena),
      .bad_o    (bad)
   );

   irqc_status_bank #(.NUM_SRC(NUM_SRC), .SRC_REVERSED(SRC_REVERSED)) u_bank (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .src_i    (src_i),
      .wr_stat_i(wr_stat),
      .wr_set_i (wr_set),
      .wr_ena_i (wr_ena),
      .wdata_i  (wdata_i[NUM_SRC-1:0]),
      .status_o (status),
      .enable_o (enable)
   );

   irqc_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .status_i(status),
      .enable_i(enable),
      .irq_o   (irq_o)
   );

   always_comb begin
      rd_bits = '0;
      if (hit) begin
         unique case (sel)
            SEL_STAT, SEL_SET: rd_bits = status;
            SEL_ENA:           rd_bits = enable;
            SEL_MASK:          rd_bits = status & enable;
            default:           rd_bits = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (rd_en_i) rdata_q <= DATA_W'(rd_bits);
         err_q   <= bad;
         armed_q <= 1'b1;
      end
   end

   assign rdata_o = rdata_q;
   assign err_o   = err_q;

   // R7
   irq_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      armed_q |-> (irq_o == $past(|(status & enable))));
   // R8
   err_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |-> $past(rd_en_i || wr_en_i));
   // R10
   rdata_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_q && !$past(rd_en_i)) |-> $stable(rdata_o));
   // R8
   unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_q && $past(rd_en_i && !hit)) |-> (rdata_o == '0));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] src = '0;
   logic [7:0]  addr = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        err, irq;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_stat = '0, m_ena = '0, m_prev = '0, m_rdata = '0;
   logic        m_irq = 1'b0, m_err = 1'b0;

   irq_status_ctrl i_irq_status_ctrl (
      .clk_i(clk), .rst_i(rst), .src_i(src), .addr_i(addr),
      .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
      .rdata_o(rdata), .err_o(err), .irq_o(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00, 8'h04: return m_stat;
         8'h08:        return m_ena;
         8'h0C:        return m_stat & m_ena;
         default:      return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h00:   return "R3";
         8'h04:   return "R4";
         8'h08:   return "R5";
         8'h0C:   return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                       input logic [31:0] d, input logic [31:0] s);
      logic [31:0] base, rise, fall;
      logic        mapped;
      @(negedge clk);
      rd_en = rd; wr_en = wr; addr = a; wdata = d; src = s;
      @(posedge clk);
      mapped = (a == 8'h00) || (a == 8'h04) || (a == 8'h08) || (a == 8'h0C);
      m_irq = |(m_stat & m_ena);
      m_err = (rd && (!mapped || a == 8'h04)) || (wr && (!mapped || a == 8'h0C));
      if (rd) m_rdata = exp_read(a);
      base = m_stat;
      if (wr && a == 8'h00) base = m_stat & ~d;
      else if (wr && a == 8'h04) base = d;
      rise = s & ~m_prev;
      fall = ~s & m_prev;
      m_stat = (base & ~fall) | rise;
      m_prev = s;
      if (wr && a == 8'h08) m_ena = d;
      #1;
      check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
      check(m_err ? tag_of(a) : "R8 err", {31'b0, err}, {31'b0, m_err});
      check(rd ? tag_of(a) : "R10", rdata, m_rdata);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] s_cur;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 err", {31'b0, err}, 32'h0);
      check("R1 rdata", rdata, 32'h0);
      @(negedge clk); rst = 1'b0;
      step(1, 0, 8'h00, 0, 0);
      check("R1 status", rdata, 32'h0);
      step(1, 0, 8'h08, 0, 0);
      check("R1 enable", rdata, 32'h0);

      // R2: rising edge sets bit 3
      step(0, 0, 8'h00, 0, 32'h8);
      step(1, 0, 8'h00, 0, 32'h8);
      check("R2 rise", rdata, 32'h8);
      // R3: clear while line stays high sticks
      step(0, 1, 8'h00, 32'hFFFF_FFFF, 32'h8);
      step(1, 0, 8'h00, 0, 32'h8);
      check("R3 w1c", rdata, 32'h0);
      step(0, 0, 8'h00, 0, 32'h0);
      step(1, 0, 8'h00, 0, 32'h0);
      check("R2 fall", rdata, 32'h0);

      // R9: edge wins over same-cycle write
      step(0, 1, 8'h04, 32'h0, 32'h20);
      step(1, 0, 8'h00, 0, 32'h20);
      check("R9 rise vs load", rdata, 32'h20);
      step(0, 1, 8'h04, 32'hFFFF_FFFF, 32'h0);
      step(1, 0, 8'h00, 0, 32'h0);
      check("R9 fall vs load", rdata, 32'hFFFF_FFDF);

      // R5 / R7: enable write, irq one cycle later
      step(0, 1, 8'h08, 32'h0000_00FF, 32'h0);
      check("R7 before", {31'b0, irq}, 32'h0);
      step(0, 0, 8'h00, 0, 32'h0);
      check("R7 after", {31'b0, irq}, 32'h1);
      step(1, 0, 8'h0C, 0, 32'h0);
      check("R6 masked", rdata, 32'h0000_00DF);
      step(0, 1, 8'h0C, 32'h0, 32'h0);
      check("R6 write err", {31'b0, err}, 32'h1);
      step(1, 0, 8'h0C, 0, 32'h0);
      check("R6 ignored", rdata, 32'h0000_00DF);
      step(1, 0, 8'h04, 0, 32'h0);
      check("R4 read err", {31'b0, err}, 32'h1);

      // R8: unmapped and misaligned
      step(1, 0, 8'h10, 0, 32'h0);
      check("R8 read zero", rdata, 32'h0);
      step(0, 1, 8'h14, 32'h0, 32'h0);
      check("R8 write err", {31'b0, err}, 32'h1);
      step(0, 0, 8'h00, 0, 32'h0);
      check("R8 one cycle", {31'b0, err}, 32'h0);
      step(0, 1, 8'h0A, 32'h0, 32'h0);
      step(1, 0, 8'h08, 0, 32'h0);
      check("R8 ignored", rdata, 32'h0000_00FF);
      // R10: held without read
      step(0, 0, 8'h08, 0, 32'h0);
      check("R10 hold", rdata, 32'h0000_00FF);

      // random phase
      void'($urandom(32'd1234));
      s_cur = '0;
      for (int n = 0; n < 3000; n++) begin
         logic [7:0]  a;
         logic [2:0]  pick;
         logic        do_rd, do_wr;
         pick = 3'($urandom_range(0, 5));
         case (pick)
            3'd0: a = 8'h00;
            3'd1: a = 8'h04;
            3'd2: a = 8'h08;
            3'd3: a = 8'h0C;
            default: a = 8'($urandom);
         endcase
         do_rd = ($urandom_range(0, 2) == 0);
         do_wr = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 3) == 0) s_cur = s_cur ^ (32'h1 << $urandom_range(0, 31));
         if ($urandom_range(0, 15) == 0) s_cur = $urandom;
         step(do_rd, do_wr, a, $urandom, s_cur);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule